// File: doc/BRIEF.md
# Chip-Select Access Timing Sequencer

This block produces the strobe waveforms for one access to a chip-select bank. A start pulse launches a sequence of three phases (setup, access and hold) whose lengths come from six 2-bit timing fields. Reads and writes each have their own three fields. When the access is made by the DMA engine, a separate DMA timing word supplies the fields and the bank's own word is not used. During the sequence the block drives a chip-select, a read or write strobe, a one-tick pulse that tells the data path when to capture read data, and a one-tick done pulse.

The sequencer runs on a clock at twice the bus rate, so one tick is half a bus clock. This lets chip-select end half a bus clock before the read strobe when the read hold is zero. The timing word is captured when a start is accepted, so the caller may change the inputs while an access is running. The block has no data stream and no valid/ready interface. All pins are plain control and status pins, and back-pressure does not apply.

After reset, boot bank 0 is expected to use zero setup and the maximum access and hold values. The package exports this word as a constant for whoever owns the bank registers.

Top module: `cs_access_seq`

## Requirements
- R1: While reset is held and right after it, cs_o, rd_o, wr_o, latch_o and done_o are all 0 and the block is idle.
- R2: The timing word is six fields of FIELD_W bits, from the top down: write setup [11:10], write access [9:8], write hold [7:6], read setup [5:4], read access [3:2], read hold [1:0]. A setup value S gives 2*S ticks with cs_o=1 and both strobes 0, starting in the tick after the edge that accepts start_i.
- R3: Setup is followed by the access phase, which lasts 2*A ticks for an access value A. A value of 0 acts as 1. In this phase cs_o=1 and exactly one strobe is 1: rd_o for a read (write_i=0) and wr_o for a write (write_i=1).
- R4: A hold value H gives 2*H ticks after the access phase, with cs_o, rd_o and wr_o all 0.
- R5: A write uses only the write fields and a read uses only the read fields.
- R6: With dma_i=1 at start, every field comes from dma_tim_i and bank_tim_i has no effect. With dma_i=0, dma_tim_i has no effect.
- R7: For a read with a nonzero read hold, latch_o pulses for one tick in the first hold tick, which is the tick after rd_o falls.
- R8: For a read with a zero read hold, cs_o drops in the last access tick, one tick (half a bus clock) before rd_o ends. latch_o pulses in that same tick.
- R9: done_o is 1 for exactly one tick, right after the hold phase ends (or right after access when the hold is 0). The block is idle in the following tick.
- R10: A start_i that arrives while an access or its done tick is in progress is ignored. A change of the timing, direction or DMA inputs after the start is accepted does not alter the running access.
- R11: A write never pulses latch_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x_i | input | 1 | Sequencer clock, twice the bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts an access when the block is idle |
| write_i | input | 1 | 1 selects a write and 0 a read, sampled at start |
| dma_i | input | 1 | 1 selects the DMA timing word, sampled at start |
| bank_tim_i | input | 12 | Bank timing word (layout in R2) |
| dma_tim_i | input | 12 | DMA timing word (same layout) |
| cs_o | output | 1 | Chip-select, active high |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| latch_o | output | 1 | One-tick read-data capture pulse |
| done_o | output | 1 | One-tick end-of-access pulse |

## Verification
The bench targets the zero-hold read. A design that ignored it would keep chip-select high through the whole read strobe and capture data one tick late, after the strobe had ended. Zero setup and zero access values are also driven. A zero setup must skip the setup phase entirely, while a zero access must still produce a two-tick strobe; a design that handled either wrongly would add or lose ticks. DMA and non-DMA accesses are given conflicting timing words, so taking fields from the wrong word, or from the wrong direction, shows up as shifted edges. Start pulses and changed timing are injected in the middle of an access and in its done tick, so a design that restarted or used live inputs would show an altered trace or a second access.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACCESS,
    PH_HOLD,
    PH_DONE
  } phase_e;

  // Slot index of each field inside a timing word; slot k spans [k*FW +: FW]
  localparam int SLOT_RD_HOLD   = 0;
  localparam int SLOT_RD_ACCESS = 1;
  localparam int SLOT_RD_SETUP  = 2;
  localparam int SLOT_WR_HOLD   = 3;
  localparam int SLOT_WR_ACCESS = 4;
  localparam int SLOT_WR_SETUP  = 5;
  localparam int NUM_SLOTS      = 6;

  // Boot bank word: zero setup, maximum access and hold (2-bit fields)
  localparam logic [11:0] BOOT_TIMING_2B = {2'd0, 2'd3, 2'd3, 2'd0, 2'd3, 2'd3};
endpackage

// File: rtl/cs_tim_select.sv
module cs_tim_select #(
  parameter int FIELD_W = 2,
  localparam int TIM_W = cs_seq_pkg::NUM_SLOTS * FIELD_W
) (
  input  logic               write_i,
  input  logic               dma_i,
  input  logic [TIM_W-1:0]   bank_tim_i,
  input  logic [TIM_W-1:0]   dma_tim_i,
  output logic [FIELD_W-1:0] setup_o,
  output logic [FIELD_W-1:0] access_o,
  output logic [FIELD_W-1:0] hold_o
);
  import cs_seq_pkg::*;

  logic [TIM_W-1:0]   word;
  logic [FIELD_W-1:0] raw_access;

  assign word = dma_i ? dma_tim_i : bank_tim_i;

  always_comb begin
    if (write_i) begin
      setup_o    = word[SLOT_WR_SETUP*FIELD_W  +: FIELD_W];
      raw_access = word[SLOT_WR_ACCESS*FIELD_W +: FIELD_W];
      hold_o     = word[SLOT_WR_HOLD*FIELD_W   +: FIELD_W];
    end else begin
      setup_o    = word[SLOT_RD_SETUP*FIELD_W  +: FIELD_W];
      raw_access = word[SLOT_RD_ACCESS*FIELD_W +: FIELD_W];
      hold_o     = word[SLOT_RD_HOLD*FIELD_W   +: FIELD_W];
    end
  end

  // Access phase never shorter than one bus clock
  assign access_o = (raw_access == '0) ? FIELD_W'(1) : raw_access;
endmodule

// File: rtl/cs_phase_ctr.sv
module cs_phase_ctr #(
  parameter int FIELD_W = 2,
  localparam int CW = FIELD_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FIELD_W-1:0] ld_setup_i,
  input  logic [FIELD_W-1:0] ld_access_i,
  input  logic [FIELD_W-1:0] sn_access_i,
  input  logic [FIELD_W-1:0] sn_hold_i,
  output cs_seq_pkg::phase_e phase_o,
  output logic [CW-1:0]      cnt_o,
  output logic               accept_o
);
  import cs_seq_pkg::*;

  // Bus clocks to last-tick index in 2x ticks
  function automatic logic [CW-1:0] ticks(input logic [FIELD_W-1:0] n);
    return {n, 1'b0} - CW'(1);
  endfunction

  phase_e        phase_n;
  logic [CW-1:0] cnt_n;

  assign accept_o = start_i && (phase_o == PH_IDLE);

  always_comb begin
    phase_n = phase_o;
    cnt_n   = cnt_o;
    unique case (phase_o)
      PH_IDLE: if (accept_o) begin
        if (ld_setup_i != '0) begin
          phase_n = PH_SETUP;
          cnt_n   = ticks(ld_setup_i);
        end else begin
          phase_n = PH_ACCESS;
          cnt_n   = ticks(ld_access_i);
        end
      end
      PH_SETUP: begin
        if (cnt_o != '0) cnt_n = cnt_o - CW'(1);
        else begin
          phase_n = PH_ACCESS;
          cnt_n   = ticks(sn_access_i);
        end
      end
      PH_ACCESS: begin
        if (cnt_o != '0) cnt_n = cnt_o - CW'(1);
        else if (sn_hold_i != '0) begin
          phase_n = PH_HOLD;
          cnt_n   = ticks(sn_hold_i);
        end else phase_n = PH_DONE;
      end
      PH_HOLD: begin
        if (cnt_o != '0) cnt_n = cnt_o - CW'(1);
        else phase_n = PH_DONE;
      end
      PH_DONE: phase_n = PH_IDLE;
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      phase_o <= PH_IDLE;
      cnt_o   <= '0;
    end else begin
      phase_o <= phase_n;
      cnt_o   <= cnt_n;
    end
  end

  // R10
  busy_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o inside {PH_SETUP, PH_ACCESS, PH_HOLD}) |=> (phase_o != PH_IDLE));

  // R9
  done_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_DONE) |=> (phase_o == PH_IDLE));
endmodule

// File: rtl/cs_strobe_gen.sv
module cs_strobe_gen #(
  parameter int FIELD_W = 2,
  localparam int CW = FIELD_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cs_seq_pkg::phase_e phase_i,
  input  logic [CW-1:0]      cnt_i,
  input  logic               sn_write_i,
  input  logic [FIELD_W-1:0] sn_hold_i,
  output logic               cs_o,
  output logic               rd_o,
  output logic               wr_o,
  output logic               latch_o,
  output logic               done_o
);
  import cs_seq_pkg::*;

  logic zero_hold_rd;
  logic last_access;
  logic first_hold;

  assign zero_hold_rd = !sn_write_i && (sn_hold_i == '0);
  assign last_access  = (phase_i == PH_ACCESS) && (cnt_i == '0);
  assign first_hold   = (phase_i == PH_HOLD) && (cnt_i == ({sn_hold_i, 1'b0} - CW'(1)));

  assign cs_o    = (phase_i == PH_SETUP) ||
                   ((phase_i == PH_ACCESS) && !(zero_hold_rd && last_access));
  assign rd_o    = (phase_i == PH_ACCESS) && !sn_write_i;
  assign wr_o    = (phase_i == PH_ACCESS) &&  sn_write_i;
  assign latch_o = !sn_write_i && (zero_hold_rd ? last_access : first_hold);
  assign done_o  = (phase_i == PH_DONE);

  // R3
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

  // R3
  strobe_under_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_o) || $rose(wr_o)) |-> cs_o);

  // R11
  latch_read_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> !wr_o);

  // R7
  latch_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> !latch_o);
endmodule

// File: rtl/cs_access_seq.sv
module cs_access_seq #(
  parameter int FIELD_W = 2,
  localparam int TIM_W = cs_seq_pkg::NUM_SLOTS * FIELD_W,
  localparam int CW = FIELD_W + 1
) (
  input  logic             clk2x_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             write_i,
  input  logic             dma_i,
  input  logic [TIM_W-1:0] bank_tim_i,
  input  logic [TIM_W-1:0] dma_tim_i,
  output logic             cs_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             latch_o,
  output logic             done_o
);
  import cs_seq_pkg::*;

  logic [FIELD_W-1:0] ld_setup, ld_access, ld_hold;
  logic [FIELD_W-1:0] sn_access, sn_hold;
  logic               sn_write;
  logic               accept;
  phase_e             phase;
  logic [CW-1:0]      cnt;

  cs_tim_select #(.FIELD_W(FIELD_W)) sel_i (
    .write_i    (write_i),
    .dma_i      (dma_i),
    .bank_tim_i (bank_tim_i),
    .dma_tim_i  (dma_tim_i),
    .setup_o    (ld_setup),
    .access_o   (ld_access),
    .hold_o     (ld_hold)
  );

  // Snapshot of the accepted access; live inputs are not used afterwards
  always_ff @(posedge clk2x_i) begin
    if (!rst_ni) begin
      sn_access <= FIELD_W'(1);
      sn_hold   <= '0;
      sn_write  <= 1'b0;
    end else if (accept) begin
      sn_access <= ld_access;
      sn_hold   <= ld_hold;
      sn_write  <= write_i;
    end
  end

  cs_phase_ctr #(.FIELD_W(FIELD_W)) ctr_i (
    .clk_i       (clk2x_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .ld_setup_i  (ld_setup),
    .ld_access_i (ld_access),
    .sn_access_i (sn_access),
    .sn_hold_i   (sn_hold),
    .phase_o     (phase),
    .cnt_o       (cnt),
    .accept_o    (accept)
  );

  cs_strobe_gen #(.FIELD_W(FIELD_W)) gen_i (
    .clk_i      (clk2x_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase),
    .cnt_i      (cnt),
    .sn_write_i (sn_write),
    .sn_hold_i  (sn_hold),
    .cs_o       (cs_o),
    .rd_o       (rd_o),
    .wr_o       (wr_o),
    .latch_o    (latch_o),
    .done_o     (done_o)
  );

  // R9
  done_quiet_chk: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
    done_o |-> (!cs_o && !rd_o && !wr_o));
endmodule

// File: tb/cs_access_seq_tb_top.sv
`timescale 1ns/1ps
module cs_access_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wr_in = 1'b0, dma_in = 1'b0;
  logic [11:0] bank_tim = '0, dma_tim = '0;
  logic cs, rd, wr, latch, done;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  cs_access_seq dut_i (
    .clk2x_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(wr_in), .dma_i(dma_in),
    .bank_tim_i(bank_tim), .dma_tim_i(dma_tim),
    .cs_o(cs), .rd_o(rd), .wr_o(wr), .latch_o(latch), .done_o(done)
  );

  function automatic logic [11:0] tw(input int ws, wa, wh, rs, ra, rh);
    return {2'(ws), 2'(wa), 2'(wh), 2'(rs), 2'(ra), 2'(rh)};
  endfunction

  // entry: {write, dma, bank word[11:0], dma word[11:0]}
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b0, 12'b00_00_00_01_10_01, 12'b00_00_00_11_11_11}, // read, hold 1 (R5, R7)
    {1'b1, 1'b0, 12'b10_01_11_00_00_00, 12'b00_00_00_00_00_00}, // write S2 A1 H3 (R5, R11)
    {1'b0, 1'b0, 12'b11_11_11_00_01_00, 12'b00_00_00_00_00_00}, // zero-hold read (R8)
    {1'b0, 1'b0, 12'b00_00_00_01_00_10, 12'b00_00_00_00_00_00}, // access 0 -> 1 (R3)
    {1'b0, 1'b1, 12'b00_00_00_11_11_11, 12'b00_00_00_00_01_01}, // DMA read (R6)
    {1'b1, 1'b1, 12'b11_11_11_00_00_00, 12'b01_10_00_11_11_11}, // DMA write (R6)
    {1'b1, 1'b0, 12'b00_11_00_00_00_00, 12'b00_00_00_00_00_00}, // write hold 0 (R11)
    {1'b0, 1'b0, 12'b00_00_00_11_11_11, 12'b00_00_00_00_00_00}, // read max (R2, R4)
    {1'b0, 1'b0, 12'b00_00_00_10_01_01, 12'b11_11_11_00_00_00}, // bank used, not DMA (R6)
    {1'b1, 1'b0, cs_seq_pkg::BOOT_TIMING_2B, 12'b00_00_00_00_00_00}  // boot word write
  };

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {cs,rd,wr,latch,done} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Runs one access; disturb injects start pulses and altered inputs (R10)
  task automatic run_vec(input logic [25:0] v, input bit disturb);
    int s, a, h, t;
    logic [11:0] w;
    logic [4:0] e;
    string req;
    w = v[24] ? v[11:0] : v[23:12];
    if (v[25]) begin s = w[11:10]; a = w[9:8]; h = w[7:6]; end
    else       begin s = w[5:4];   a = w[3:2]; h = w[1:0]; end
    if (a == 0) a = 1;
    t = 2*s + 2*a + 2*h;
    @(negedge clk);
    wr_in = v[25]; dma_in = v[24]; bank_tim = v[23:12]; dma_tim = v[11:0]; start = 1'b1;
    for (int n = 1; n <= t + 4; n++) begin
      @(negedge clk);
      #1;
      e = '0;
      if (n <= 2*s) begin e[4] = 1'b1; req = "R2"; end
      else if (n <= 2*s + 2*a) begin
        e[3] = !v[25]; e[2] = v[25]; e[4] = 1'b1; req = "R3";
        if (n == 2*s + 2*a && !v[25] && h == 0) begin e[4] = 1'b0; e[1] = 1'b1; req = "R8"; end
      end else if (n <= t) begin
        req = "R4";
        if (n == 2*s + 2*a + 1 && !v[25]) begin e[1] = 1'b1; req = "R7"; end
      end else if (n == t + 1) begin e[0] = 1'b1; req = "R9"; end
      else req = "R10";
      chk(req, {cs, rd, wr, latch, done}, e);
      start = 1'b0;
      if (disturb && n == 2) begin
        start = 1'b1; wr_in = ~wr_in; dma_in = ~dma_in; bank_tim = '0; dma_tim = '1;
      end
      if (disturb && n == t + 1) start = 1'b1;  // during done tick: ignored
    end
    start = 1'b0;
  endtask

  initial begin
    fork
      begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
      begin
        repeat (3) @(negedge clk);
        chk("R1", {cs, rd, wr, latch, done}, 5'b0);   // R1 during reset
        start = 1'b1;                                  // ignored while in reset
        @(negedge clk);
        chk("R1", {cs, rd, wr, latch, done}, 5'b0);
        start = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {cs, rd, wr, latch, done}, 5'b0);   // R1 after release
        for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);
        run_vec(VEC[7], 1'b1);  // R10 mid-access start and input change
        run_vec(VEC[2], 1'b1);  // R10 on zero-hold read
        run_vec(VEC[1], 1'b1);  // R10 on write
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule